// File: doc/BRIEF.md
# Unit Reset, Halt and Command Pulse Registers

This block is a small register file on a synchronous microprocessor bus. It gives software direct control of one attached functional unit. A two-bit control register holds the unit's reset and halt lines. One or more command registers turn each written 1 into a single-cycle event pulse towards the unit.

The unit's reset line comes out of power-on reset asserted, so the unit stays disabled until software clears it. Reading the control register returns the stored bits. Command registers have no storage: reading one always returns zero, and writing a 0 to a command bit does nothing.

Read data is registered. `rdata_o` carries the addressed value in the cycle after `rd_i` is sampled high, and is zero in every other cycle.

Top module: `ctl_pulse_regs`

## Requirements
- R1: After `rst_ni` is released, `unit_rst_o` is 1, `unit_halt_o` is 0, `cmd_pulse_o` is all zeros and `rdata_o` is zero.
- R2: A write to address 0x30 loads data bit 0 into `unit_rst_o` and data bit 1 into `unit_halt_o`, both visible from the cycle after the write. Data bits 7:2 are ignored.
- R3: A read of address 0x30 returns, in the cycle after the read, bits 7:2 as 0, bit 1 as halt and bit 0 as reset.
- R4: Writing 1 to bit j of the command register at address 0x31+k drives `cmd_pulse_o[k*8+j]` high for exactly the one cycle after the write. With no further write, the bit returns low by itself.
- R5: Command bits written as 0 produce no pulse. Several bits written as 1 in one write all pulse in the same cycle.
- R6: A read of any command register (0x31 or 0x32) returns zero.
- R7: Writes to unmapped addresses change no output, and reads of unmapped addresses return zero.
- R8: `rdata_o` is zero in any cycle not preceded by a sampled read.
- R9: The control register keeps its value in every cycle without a write to 0x30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and unit clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe, sampled on the rising edge |
| rd_i | input | 1 | Read strobe, sampled on the rising edge |
| rdata_o | output | 8 | Registered read data |
| unit_rst_o | output | 1 | Reset line to the unit, active high |
| unit_halt_o | output | 1 | Halt line to the unit, freezes its state machines |
| cmd_pulse_o | output | 16 | Command event pulses, bit k*8+j for register k, bit j |

## Verification
The command registers are driven with several patterns. A single low bit and a single top bit show that each bit reaches its own output position. A mixed pattern (0xA5) shows that written zeros stay silent while the ones fire together. All ones and all zeros bound the range.

Every write is followed by an idle cycle, which separates a true one-cycle pulse from a level that lingers. The control register is written with noise in the upper bits, and with every combination of its two bits, to tell stored bits from ignored ones. Writes and reads just outside the mapped range (0x2F, 0x33) show that the address decode leaks nothing.

// File: rtl/ctl_pulse_pkg.sv
package ctl_pulse_pkg;
  localparam int unsigned CTRL_W = 2;

  typedef struct packed {
    logic halt;
    logic rst;
  } ctrl_t;

  localparam ctrl_t CTRL_POR = '{halt: 1'b0, rst: 1'b1};
endpackage

// File: rtl/ctl_pulse_dec.sv
module ctl_pulse_dec #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned CTRL_ADDR = 'h30,
  parameter int unsigned CMD_BASE  = 'h31,
  parameter int unsigned N_CMD     = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_ctrl_o,
  output logic [N_CMD-1:0]  hit_cmd_o
);
  assign hit_ctrl_o = (addr_i == ADDR_W'(CTRL_ADDR));

  for (genvar k = 0; k < N_CMD; k++) begin : g_cmd_hit
    assign hit_cmd_o[k] = (addr_i == ADDR_W'(CMD_BASE + k));
  end
endmodule

// File: rtl/ctl_pulse_ctrl.sv
module ctl_pulse_ctrl
  import ctl_pulse_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output ctrl_t             ctrl_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= CTRL_POR;
    else if (we_i) ctrl_q <= ctrl_t'(wdata_i);
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/ctl_pulse_cmd.sv
module ctl_pulse_cmd #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] pulse_o
);
  logic [DATA_W-1:0] pulse_q;

  // Self-clearing: any cycle without a write drops every bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pulse_q <= '0;
    else if (we_i) pulse_q <= wdata_i;
    else           pulse_q <= '0;
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/ctl_pulse_regs.sv
module ctl_pulse_regs
  import ctl_pulse_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CTRL_ADDR = 'h30,
  parameter int unsigned CMD_BASE  = 'h31,
  parameter int unsigned N_CMD     = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  input  logic                      wr_i,
  input  logic                      rd_i,
  output logic [DATA_W-1:0]         rdata_o,
  output logic                      unit_rst_o,
  output logic                      unit_halt_o,
  output logic [N_CMD*DATA_W-1:0]   cmd_pulse_o
);
  localparam int unsigned PULSE_W = N_CMD * DATA_W;

  logic             hit_ctrl;
  logic [N_CMD-1:0] hit_cmd;
  ctrl_t            ctrl;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  ctl_pulse_dec #(
    .ADDR_W   (ADDR_W),
    .CTRL_ADDR(CTRL_ADDR),
    .CMD_BASE (CMD_BASE),
    .N_CMD    (N_CMD)
  ) i_dec (
    .addr_i    (addr_i),
    .hit_ctrl_o(hit_ctrl),
    .hit_cmd_o (hit_cmd)
  );

  ctl_pulse_ctrl i_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_i && hit_ctrl),
    .wdata_i(wdata_i[CTRL_W-1:0]),
    .ctrl_o (ctrl)
  );

  for (genvar k = 0; k < N_CMD; k++) begin : g_cmd
    ctl_pulse_cmd #(.DATA_W(DATA_W)) i_cmd (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (wr_i && hit_cmd[k]),
      .wdata_i(wdata_i),
      .pulse_o(cmd_pulse_o[k*DATA_W +: DATA_W])
    );
  end

  // Command registers have no storage to read back
  always_comb begin
    rd_mux = '0;
    if (hit_ctrl) rd_mux[CTRL_W-1:0] = ctrl;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
    else           rdata_q <= '0;
  end

  assign rdata_o     = rdata_q;
  assign unit_rst_o  = ctrl.rst;
  assign unit_halt_o = ctrl.halt;

  logic unused_w;
  assign unused_w = ^PULSE_W;
endmodule

// File: rtl/ctl_pulse_regs_chk.sv
module ctl_pulse_regs_chk #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CTRL_ADDR = 'h30,
  parameter int unsigned CMD_BASE  = 'h31,
  parameter int unsigned N_CMD     = 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [ADDR_W-1:0]       addr_i,
  input logic [DATA_W-1:0]       wdata_i,
  input logic                    wr_i,
  input logic                    rd_i,
  input logic [DATA_W-1:0]       rdata_o,
  input logic                    unit_rst_o,
  input logic                    unit_halt_o,
  input logic [N_CMD*DATA_W-1:0] cmd_pulse_o
);
  logic at_ctrl, at_cmd, at_map;
  assign at_ctrl = (int'(addr_i) == CTRL_ADDR);
  assign at_cmd  = (int'(addr_i) >= CMD_BASE) && (int'(addr_i) < CMD_BASE + N_CMD);
  assign at_map  = at_ctrl || at_cmd;

  p_pulse_needs_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && at_cmd) |=> (cmd_pulse_o == '0));

  p_ctrl_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && at_ctrl) |=> (unit_rst_o == $past(wdata_i[0])) && (unit_halt_o == $past(wdata_i[1])));

  p_ctrl_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && at_ctrl) |=> $stable(unit_rst_o) && $stable(unit_halt_o));

  p_ctrl_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && at_ctrl) |=> (rdata_o == {{(DATA_W-2){1'b0}}, $past(unit_halt_o), $past(unit_rst_o)}));

  p_cmd_read_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && at_cmd) |=> (rdata_o == '0));

  p_unmapped_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !at_map) |=> (rdata_o == '0));

  p_idle_rdata_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> (rdata_o == '0));
endmodule

bind ctl_pulse_regs ctl_pulse_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR),
  .CMD_BASE(CMD_BASE), .N_CMD(N_CMD)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
  .wr_i(wr_i), .rd_i(rd_i), .rdata_o(rdata_o), .unit_rst_o(unit_rst_o),
  .unit_halt_o(unit_halt_o), .cmd_pulse_o(cmd_pulse_o)
);

// File: tb/test_ctl_pulse_regs.sv
`timescale 1ns/1ps
module test_ctl_pulse_regs;
  localparam time TCK = 5ns;
  localparam int  NV  = 11;

  // {addr, wdata, 6'b0, exp_halt, exp_rst, exp_cmd[15:0]}
  localparam logic [39:0] VEC [NV] = '{
    {8'h30, 8'h00, 6'd0, 1'b0, 1'b0, 16'h0000},  // R2 release reset
    {8'h31, 8'h01, 6'd0, 1'b0, 1'b0, 16'h0001},  // R4 low bit
    {8'h31, 8'hA5, 6'd0, 1'b0, 1'b0, 16'h00A5},  // R5 mixed
    {8'h32, 8'h80, 6'd0, 1'b0, 1'b0, 16'h8000},  // R4 top bit reg 1
    {8'h32, 8'hFF, 6'd0, 1'b0, 1'b0, 16'hFF00},  // R5 all ones
    {8'h30, 8'hFE, 6'd0, 1'b1, 1'b0, 16'h0000},  // R2 upper bits ignored
    {8'h31, 8'h00, 6'd0, 1'b1, 1'b0, 16'h0000},  // R5 zeros silent
    {8'h33, 8'hFF, 6'd0, 1'b1, 1'b0, 16'h0000},  // R7 above map
    {8'h2F, 8'h03, 6'd0, 1'b1, 1'b0, 16'h0000},  // R7 below map
    {8'h30, 8'h03, 6'd0, 1'b1, 1'b1, 16'h0000},  // R2 both set
    {8'h30, 8'h01, 6'd0, 1'b0, 1'b1, 16'h0000}   // R2 halt cleared
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        wr_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [7:0]  rdata_o;
  logic        unit_rst_o, unit_halt_o;
  logic [15:0] cmd_pulse_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(TCK/2) clk_i = ~clk_i;

  ctl_pulse_regs i_ctl_pulse_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_i(wr_i), .rd_i(rd_i), .rdata_o(rdata_o), .unit_rst_o(unit_rst_o),
    .unit_halt_o(unit_halt_o), .cmd_pulse_o(cmd_pulse_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(posedge clk_i); #1;
    @(negedge clk_i);
    wr_i = 1'b0; addr_i = '0; wdata_i = '0;
  endtask

  // Result sampled 1 ns after the read edge
  task automatic bus_read(logic [7:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    @(posedge clk_i); #1;
    d = rdata_o;
    @(negedge clk_i);
    rd_i = 1'b0; addr_i = '0;
  endtask

  initial begin
    #(TCK * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 rst",   unit_rst_o,  1'b1);
    check("R1 halt",  unit_halt_o, 1'b0);
    check("R1 pulse", cmd_pulse_o, 16'h0);
    check("R1 rdata", rdata_o,     8'h0);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk_i);
      addr_i = VEC[v][39:32]; wdata_i = VEC[v][31:24]; wr_i = 1'b1;
      @(posedge clk_i); #1;
      check("R4/R5 pulse", cmd_pulse_o, VEC[v][15:0]);
      @(negedge clk_i);
      wr_i = 1'b0; addr_i = '0; wdata_i = '0;
      check("R2/R7 rst",  unit_rst_o,  VEC[v][16]);
      check("R2/R7 halt", unit_halt_o, VEC[v][17]);
      @(posedge clk_i); #1;
      check("R4 self-clear", cmd_pulse_o, 16'h0);
      check("R9 hold", {unit_halt_o, unit_rst_o}, VEC[v][17:16]);
    end

    // Control register readback
    bus_read(8'h30, rd);
    check("R3 read 01", rd, 8'h01);
    bus_write(8'h30, 8'h02);
    bus_read(8'h30, rd);
    check("R3 read 02", rd, 8'h02);
    bus_write(8'h30, 8'hFF);
    bus_read(8'h30, rd);
    check("R3 read 03", rd, 8'h03);

    // Command readback after writing ones
    bus_write(8'h31, 8'hFF);
    bus_read(8'h31, rd);
    check("R6 cmd0 read", rd, 8'h00);
    bus_read(8'h32, rd);
    check("R6 cmd1 read", rd, 8'h00);

    bus_read(8'h33, rd);
    check("R7 unmapped read", rd, 8'h00);
    bus_read(8'h00, rd);
    check("R7 unmapped read 0", rd, 8'h00);

    @(posedge clk_i); #1;
    check("R8 idle rdata", rdata_o, 8'h00);

    // Back-to-back writes: one pulse per write
    @(negedge clk_i);
    addr_i = 8'h32; wdata_i = 8'h01; wr_i = 1'b1;
    @(posedge clk_i); #1;
    check("R4 b2b first", cmd_pulse_o, 16'h0100);
    @(negedge clk_i);
    wdata_i = 8'h02;
    @(posedge clk_i); #1;
    check("R4 b2b second", cmd_pulse_o, 16'h0200);
    @(negedge clk_i);
    wr_i = 1'b0; addr_i = '0; wdata_i = '0;
    @(posedge clk_i); #1;
    check("R4 b2b clear", cmd_pulse_o, 16'h0000);

    // Power-on reset mid-run restores defaults
    @(negedge clk_i) rst_ni = 1'b0;
    #1;
    check("R1 async rst", unit_rst_o,  1'b1);
    check("R1 async halt", unit_halt_o, 1'b0);
    @(negedge clk_i) rst_ni = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule